// File: doc/BRIEF.md
# Serial Memory Write-Protect and Status Unit

This unit holds the status byte of a serial nonvolatile memory and decides whether any pending write may commit. A command front-end handles the serial protocol. It sends this unit a few one-cycle events: a write-enable or write-disable opcode was accepted, an array-write or status-write command has started, or chip select has risen. With the chip-select event it also says whether the rise fell inside the commit window, meaning after the last data bit and before the next clock.

The unit tracks the following state:
- a volatile write-enable latch;
- the persistent protection bits (pin-enable and the two block bits);
- a busy flag, which covers the internal write time.

It also samples the active-low write-protect pin and a low-supply lockout input. On a granted commit it pulses either an array-commit or a status-commit strobe. It also reports, without a clock delay, whether the current target address lies in the protected region.

The persistent bits are plain registers. The synchronous soft reset keeps them, while the asynchronous full reset clears every bit.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0: pin-enable, three bits that are always 0, block bit 1, block bit 0, write-enable latch, and busy (1 = write in progress). All bits are 0 after full reset.
- R2: `addrProt` is 1 when `wrAddr` lies in the protected region. The region is chosen by the two block bits: 00 protects nothing, 01 protects addresses with both top address bits set (0x3000–0x3FFF for 14 bits), 10 protects addresses with the top bit set (0x2000–0x3FFF), and 11 protects every address.
- R3: `wrenHit` sets the write-enable latch and `wrdiHit` clears it. When both arrive in the same cycle, the clear wins. Both have effect one cycle later.
- R4: A command start (`cmdKind` 1 = array write, 2 = status write; 0 and 3 unused) seen while the latch is 0 is discarded and never commits.
- R5: When a write cycle finishes, the latch clears in the same cycle that busy falls.
- R6: A committed status write changes only pin-enable, block bit 1 and block bit 0. These take `wrsrData` bits 7, 3 and 2 when busy falls. Outside a write cycle these three bits never change.
- R7: A status write is cancelled if pin-enable is 1 and `wpN` is low in any cycle from its start up to and including its commit chip-select rise. `wpN` never blocks an array write.
- R8: A commit raises busy in the cycle after the chip-select rise, together with a one-cycle commit strobe. Busy stays high for exactly `WR_CYCLES` cycles. During that time every command, latch strobe, chip-select event and `wpN` level is ignored.
- R9: An array write whose address is protected at the chip-select rise does not commit.
- R10: While `lowVcc` is 1, a chip-select rise commits nothing, whatever the latch holds.
- R11: `softRst` clears the latch, busy and any pending command, and keeps the three persistent bits.
- R12: A chip-select rise outside the commit window (`csAtCommit` = 0) drops the pending command with no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous full reset, active low |
| softRst | input | 1 | Synchronous soft reset; keeps persistent bits |
| wrenHit | input | 1 | Write-enable opcode accepted |
| wrdiHit | input | 1 | Write-disable opcode accepted |
| cmdStart | input | 1 | Write command opcode accepted |
| cmdKind | input | 2 | 1 array write, 2 status write |
| csRise | input | 1 | Chip select went high |
| csAtCommit | input | 1 | That rise lay in the commit window |
| wrAddr | input | ADDR_W | Target address of the array write |
| wrsrData | input | 8 | Status write data byte |
| wpN | input | 1 | Write-protect pin, active low |
| lowVcc | input | 1 | Low-supply lockout |
| statusByte | output | 8 | Status byte as read by software |
| addrProt | output | 1 | `wrAddr` is in the protected region |
| arrayCommit | output | 1 | One-cycle array write commit |
| statusCommit | output | 1 | One-cycle status write commit |
| busy | output | 1 | Internal write in progress |

## Verification
The bench builds the unit with a 14-bit address and `WR_CYCLES` = 6. The 14-bit address puts the quarter and half region edges at 0x3000 and 0x2000, so the boundary addresses on either side can be hit directly. The short write cycle lets thousands of commits, cancels and busy windows fit in a short random run. Within that run, soft resets and lockout pulses land inside pending commands and inside write cycles.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_ARRAY  = 2'd1,
    CMD_STATUS = 2'd2,
    CMD_RSVD   = 2'd3
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setWen;
    logic clrWen;
    logic grabStatus;
    logic applyStatus;
  } wpStrobe_t;
endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strb,
  input  logic [7:0]        wrsrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busyIn,
  output logic              wen,
  output logic              wpEn,
  output logic              addrProt,
  output logic [7:0]        statusByte
);
  localparam int MSB = ADDR_W - 1;

  logic       wenQ;
  logic       wpEnQ;
  logic [1:0] bpQ;
  logic [2:0] stageQ;
  logic       unusedBits;

  assign unusedBits = ^{wrsrData[6:4], wrsrData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wenQ <= 1'b0;
    end else if (strb.clrWen) begin
      wenQ <= 1'b0;
    end else if (strb.setWen) begin
      wenQ <= 1'b1;
    end
  end

  // persistent bits: only the full reset clears them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
      wpEnQ  <= 1'b0;
      bpQ    <= 2'b00;
    end else begin
      if (strb.grabStatus) begin
        stageQ <= {wrsrData[7], wrsrData[3], wrsrData[2]};
      end
      if (strb.applyStatus) begin
        wpEnQ <= stageQ[2];
        bpQ   <= stageQ[1:0];
      end
    end
  end

  always_comb begin
    unique case (bpQ)
      2'b00:   addrProt = 1'b0;
      2'b01:   addrProt = &addr[MSB -: 2];
      2'b10:   addrProt = addr[MSB];
      default: addrProt = 1'b1;
    endcase
  end

  assign wen        = wenQ;
  assign wpEn       = wpEnQ;
  assign statusByte = {wpEnQ, 3'b000, bpQ, wenQ, busyIn};

  // R6: persistent bits move only on an apply strobe
  p_nv_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyStatus |=> $stable({wpEnQ, bpQ}));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int WR_CYCLES = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      softRst,
  input  logic      wrenHit,
  input  logic      wrdiHit,
  input  logic      cmdStart,
  input  cmdKind_e  cmdKind,
  input  logic      csRise,
  input  logic      csAtCommit,
  input  logic      wpN,
  input  logic      lowVcc,
  input  logic      wen,
  input  logic      wpEn,
  input  logic      addrProt,
  output wpStrobe_t strb,
  output logic      busy,
  output logic      arrayCommit,
  output logic      statusCommit
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  cmdKind_e   pendQ;
  logic       cancelQ;
  logic       busyQ;
  logic [CNT_W-1:0] cntQ;
  logic       kindStatusQ;
  logic       aCommitQ;
  logic       sCommitQ;

  logic wpBlock;
  logic cancelNow;
  logic targetOk;
  logic commitOk;
  logic lastTick;

  assign wpBlock   = wpEn && !wpN;
  assign cancelNow = cancelQ || (pendQ == CMD_STATUS && wpBlock);
  assign targetOk  = (pendQ == CMD_STATUS) || (pendQ == CMD_ARRAY && !addrProt);
  assign commitOk  = !busyQ && csRise && csAtCommit && !lowVcc && wen
                     && !cancelNow && targetOk;
  assign lastTick  = busyQ && (cntQ == CNT_W'(1));

  always_comb begin
    strb.setWen      = !softRst && !busyQ && wrenHit;
    strb.clrWen      = softRst || lastTick || (!busyQ && wrdiHit);
    strb.grabStatus  = !softRst && commitOk && (pendQ == CMD_STATUS);
    strb.applyStatus = !softRst && lastTick && kindStatusQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ       <= CMD_NONE;
      cancelQ     <= 1'b0;
      busyQ       <= 1'b0;
      cntQ        <= '0;
      kindStatusQ <= 1'b0;
      aCommitQ    <= 1'b0;
      sCommitQ    <= 1'b0;
    end else if (softRst) begin
      pendQ       <= CMD_NONE;
      cancelQ     <= 1'b0;
      busyQ       <= 1'b0;
      cntQ        <= '0;
      kindStatusQ <= 1'b0;
      aCommitQ    <= 1'b0;
      sCommitQ    <= 1'b0;
    end else begin
      aCommitQ <= commitOk && (pendQ == CMD_ARRAY);
      sCommitQ <= commitOk && (pendQ == CMD_STATUS);
      if (busyQ) begin
        cntQ <= cntQ - CNT_W'(1);
        if (lastTick) begin
          busyQ <= 1'b0;
        end
      end else if (csRise) begin
        pendQ   <= CMD_NONE;
        cancelQ <= 1'b0;
        if (commitOk) begin
          busyQ       <= 1'b1;
          cntQ        <= CNT_W'(WR_CYCLES);
          kindStatusQ <= (pendQ == CMD_STATUS);
        end
      end else if (cmdStart && cmdKind != CMD_NONE) begin
        if (wen) begin
          pendQ   <= cmdKind;
          cancelQ <= (cmdKind == CMD_STATUS) && wpBlock;
        end else begin
          pendQ   <= CMD_NONE;
          cancelQ <= 1'b0;
        end
      end else begin
        cancelQ <= cancelNow;
      end
    end
  end

  assign busy         = busyQ;
  assign arrayCommit  = aCommitQ;
  assign statusCommit = sCommitQ;

  // R4: nothing commits without the latch set at the chip-select rise
  p_commit_needs_wen_r4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (aCommitQ || sCommitQ) |-> $past(wen));
  // R5: the latch is clear once a write cycle ends
  p_wen_clear_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> !wen);
  // R8: a commit strobe is single and comes with busy
  p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aCommitQ || sCommitQ) |-> busyQ);
  p_commit_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aCommitQ, sCommitQ}));
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WR_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrenHit,
  input  logic              wrdiHit,
  input  logic              cmdStart,
  input  logic [1:0]        cmdKind,
  input  logic              csRise,
  input  logic              csAtCommit,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrsrData,
  input  logic              wpN,
  input  logic              lowVcc,
  output logic [7:0]        statusByte,
  output logic              addrProt,
  output logic              arrayCommit,
  output logic              statusCommit,
  output logic              busy
);
  wpStrobe_t strb;
  logic      wen;
  logic      wpEn;

  wp_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .softRst     (softRst),
    .wrenHit     (wrenHit),
    .wrdiHit     (wrdiHit),
    .cmdStart    (cmdStart),
    .cmdKind     (cmdKind_e'(cmdKind)),
    .csRise      (csRise),
    .csAtCommit  (csAtCommit),
    .wpN         (wpN),
    .lowVcc      (lowVcc),
    .wen         (wen),
    .wpEn        (wpEn),
    .addrProt    (addrProt),
    .strb        (strb),
    .busy        (busy),
    .arrayCommit (arrayCommit),
    .statusCommit(statusCommit)
  );

  wp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrsrData  (wrsrData),
    .addr      (wrAddr),
    .busyIn    (busy),
    .wen       (wen),
    .wpEn      (wpEn),
    .addrProt  (addrProt),
    .statusByte(statusByte)
  );

  // R9: a protected target never commits
  p_no_prot_commit_r9: assert property (@(posedge clk) disable iff (!rstN || softRst)
    arrayCommit |-> !$past(addrProt));
  // R10: lockout blocks every commit
  p_lockout_r10: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (arrayCommit || statusCommit) |-> !$past(lowVcc));
  // R6: protection fields stay put outside a write cycle
  p_status_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(statusByte[7:2]));
endmodule

// File: tb/tb_wp_status_unit.sv
`timescale 1ns/1ps
module tb_wp_status_unit;
  localparam int ADDR_W = 14;
  localparam int WR_CYCLES = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 0, wrenHit = 0, wrdiHit = 0, cmdStart = 0;
  logic [1:0] cmdKind = 0;
  logic csRise = 0, csAtCommit = 0;
  logic [ADDR_W-1:0] wrAddr = 0;
  logic [7:0] wrsrData = 0;
  logic wpN = 1, lowVcc = 0;
  logic [7:0] statusByte;
  logic addrProt, arrayCommit, statusCommit, busy;

  always #2 clk = ~clk;

  wp_status_unit #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrenHit(wrenHit), .wrdiHit(wrdiHit),
    .cmdStart(cmdStart), .cmdKind(cmdKind), .csRise(csRise), .csAtCommit(csAtCommit),
    .wrAddr(wrAddr), .wrsrData(wrsrData), .wpN(wpN), .lowVcc(lowVcc),
    .statusByte(statusByte), .addrProt(addrProt), .arrayCommit(arrayCommit),
    .statusCommit(statusCommit), .busy(busy));

  int nChecks = 0;
  int nFails = 0;
  string tag = "R1";

  // reference state
  logic mWen = 0, mWpen = 0, mBusy = 0, mCancel = 0, mKindS = 0, mA = 0, mS = 0;
  logic [1:0] mBp = 0, mPend = 0;
  logic [2:0] mData = 0;
  int mCnt = 0;

  function automatic logic protOf(logic [1:0] bp, logic [ADDR_W-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10: return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStatus();
    return {mWpen, 3'b000, mBp, mWen, mBusy};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mWen = 0; mWpen = 0; mBusy = 0; mCancel = 0; mKindS = 0; mA = 0; mS = 0;
    mBp = 0; mPend = 0; mData = 0; mCnt = 0;
  endtask

  task automatic modelStep();
    logic oldWen, blk, cNow, ok;
    if (softRst) begin
      mWen = 0; mBusy = 0; mCnt = 0; mPend = 0; mCancel = 0; mKindS = 0; mA = 0; mS = 0;
      return;
    end
    mA = 0; mS = 0;
    if (mBusy) begin
      if (mCnt == 1) begin
        mBusy = 0; mWen = 0;
        if (mKindS) {mWpen, mBp} = mData;
      end
      mCnt--;
      return;
    end
    oldWen = mWen;
    blk = mWpen && !wpN;
    cNow = mCancel || (mPend == 2 && blk);
    ok = csRise && csAtCommit && !lowVcc && oldWen && !cNow &&
         (mPend == 2 || (mPend == 1 && !protOf(mBp, wrAddr)));
    if (wrdiHit) mWen = 0; else if (wrenHit) mWen = 1;
    if (csRise) begin
      if (ok) begin
        mBusy = 1; mCnt = WR_CYCLES; mKindS = (mPend == 2);
        if (mPend == 2) mData = {wrsrData[7], wrsrData[3], wrsrData[2]};
        mA = (mPend == 1); mS = (mPend == 2);
      end
      mPend = 0; mCancel = 0;
    end else if (cmdStart && cmdKind != 0) begin
      if (oldWen) begin mPend = cmdKind; mCancel = (cmdKind == 2) && blk; end
      else begin mPend = 0; mCancel = 0; end
    end else begin
      mCancel = cNow;
    end
  endtask

  // inputs are set just after a falling edge; one clock is applied and compared
  task automatic tick();
    #1;
    chk({tag, " R2 addrProt"}, addrProt, protOf(mBp, wrAddr));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk({tag, " R1 status"}, statusByte, expStatus());
    chk({tag, " R8 busy"}, busy, mBusy);
    chk({tag, " arrayCommit"}, arrayCommit, mA);
    chk({tag, " statusCommit"}, statusCommit, mS);
    softRst = 0; wrenHit = 0; wrdiHit = 0; cmdStart = 0; cmdKind = 0;
    csRise = 0; csAtCommit = 0;
  endtask

  task automatic waitIdle();
    while (mBusy) tick();
    tick();
  endtask

  task automatic doWren();
    wrenHit = 1; tick();
  endtask

  logic gotA, gotS;
  task automatic doCmd(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d, input logic bnd, input logic wpMid);
    wrAddr = a; wrsrData = d;
    cmdStart = 1; cmdKind = k; tick();
    wpN = !wpMid; tick();
    wpN = 1; tick();
    csRise = 1; csAtCommit = bnd; tick();
    gotA = arrayCommit; gotS = statusCommit;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    tag = "R1";
    chk("R1 reset status", statusByte, 8'h00);
    chk("R5 reset wen", statusByte[1], 1'b0);

    tag = "R3";
    doWren();
    chk("R3 wren sets latch", statusByte, 8'h02);
    wrenHit = 1; wrdiHit = 1; tick();
    chk("R3 clear wins", statusByte[1], 1'b0);

    tag = "R4";
    doCmd(2'd2, '0, 8'hFF, 1'b1, 1'b0);
    chk("R4 discarded without wen", gotS, 1'b0);

    tag = "R6";
    doWren();
    doCmd(2'd2, '0, 8'hFF, 1'b1, 1'b0);
    chk("R6 status commit", gotS, 1'b1);
    chk("R8 busy bit set", statusByte[0], 1'b1);
    wpN = 0; tick(); wpN = 1;
    waitIdle();
    chk("R6 only three bits written", statusByte, 8'h8C);
    chk("R5 wen cleared at end", statusByte[1], 1'b0);

    tag = "R2";
    wrAddr = 14'h0000; #1;
    chk("R2 full region", addrProt, 1'b1);
    doWren();
    doCmd(2'd2, '0, 8'h04, 1'b1, 1'b0);
    waitIdle();
    wrAddr = 14'h2FFF; #1;
    chk("R2 quarter below edge", addrProt, 1'b0);
    wrAddr = 14'h3000; #1;
    chk("R2 quarter at edge", addrProt, 1'b1);

    tag = "R9";
    doWren();
    doCmd(2'd1, 14'h3000, 8'h00, 1'b1, 1'b0);
    chk("R9 protected not committed", gotA, 1'b0);
    doCmd(2'd1, 14'h2FFF, 8'h00, 1'b1, 1'b0);
    chk("R9 unprotected committed", gotA, 1'b1);
    tag = "R8";
    wrenHit = 1; tick();
    waitIdle();
    chk("R8 wren ignored while busy", statusByte[1], 1'b0);

    tag = "R7";
    doWren();
    doCmd(2'd2, '0, 8'h80, 1'b1, 1'b0);
    waitIdle();
    chk("R7 pin enable set", statusByte, 8'h80);
    doWren();
    doCmd(2'd2, '0, 8'h0C, 1'b1, 1'b1);
    chk("R7 pin cancels status write", gotS, 1'b0);
    doCmd(2'd1, 14'h0100, 8'h00, 1'b1, 1'b1);
    chk("R7 pin ignored for array", gotA, 1'b1);
    waitIdle();

    tag = "R10";
    doWren();
    lowVcc = 1;
    doCmd(2'd1, 14'h0100, 8'h00, 1'b1, 1'b0);
    lowVcc = 0;
    chk("R10 lockout blocks", gotA, 1'b0);

    tag = "R12";
    doCmd(2'd1, 14'h0100, 8'h00, 1'b0, 1'b0);
    chk("R12 outside window", gotA, 1'b0);

    tag = "R11";
    softRst = 1; tick();
    chk("R11 soft reset keeps nv", statusByte, 8'h80);

    tag = "RND";
    for (int i = 0; i < 6000; i++) begin
      wrenHit   = ($urandom_range(0, 9) == 0);
      wrdiHit   = ($urandom_range(0, 19) == 0);
      cmdStart  = ($urandom_range(0, 6) == 0);
      cmdKind   = 2'($urandom_range(1, 2));
      csRise    = ($urandom_range(0, 5) == 0);
      csAtCommit = ($urandom_range(0, 9) < 7);
      wpN       = ($urandom_range(0, 4) != 0);
      lowVcc    = ($urandom_range(0, 19) == 0);
      softRst   = ($urandom_range(0, 149) == 0);
      wrAddr    = ADDR_W'($urandom);
      wrsrData  = 8'($urandom);
      tick();
    end

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule